// File: doc/BRIEF.md
# Tile Pattern Pixel Fetcher

This block turns one tile name word into the 64 display pixels of an 8x8 four-bit-per-pixel tile. A name is taken through a valid/ready start handshake. The fetcher splits the name into a tile index, a palette number and two mirror bits. It reads the tile's pattern bytes from video memory, picks the correct nibble for each screen position, and looks the colour up in a 64-word colour memory. The pixels leave one by one on a valid/ready stream, top row first and left to right within a row.

Both memory ports are plain synchronous read ports. The fetcher raises an enable together with an address, and the data is valid in the next cycle. Colour number 0 marks a see-through pixel. It never reaches the colour memory and is delivered with a transparent flag and black RGB. Each colour word holds three 4-bit channel fields. Each field is moved into the top nibble of its own 8-bit output channel, and the channel order is reversed on the way. A one-cycle done pulse closes each tile.

Top module: `tile_pixel_fetcher`

## Requirements
- R1: `start_ready` is high only while the fetcher is idle. A name is captured on the clock edge where `start_valid` and `start_ready` are both high. While a tile is in progress, `start_valid` and `start_name` have no effect on the pixels produced.
- R2: Name bits 10:0 form the tile index. The video byte address is index×32 + row×4 + column, where row is 0..7 and column is 0..3 with four bytes per row.
- R3: When name bit 12 is set, the tile is mirrored vertically: screen row r is read from stored row 7−r.
- R4: When name bit 11 is set, the tile is mirrored horizontally. Screen byte column c is read from stored column 3−c, and the low nibble of each byte is shown before the high nibble.
- R5: Each tile gives exactly 64 accepted pixels in raster order. Without horizontal mirroring, the high nibble (bits 7:4) of a byte is the left pixel of the pair.
- R6: A colour number of 0 gives `pix_transparent`=1 and `pix_rgb`=0 for any palette, and it starts no colour memory read.
- R7: Name bits 14:13 select the palette. The colour memory word index is palette×16 + colour, so `cram_rd_addr` = {palette, colour}.
- R8: For a non-zero colour, with colour word w, `pix_rgb` = {w[3:0],4'h0, w[7:4],4'h0, w[11:8],4'h0}, and `pix_transparent` is 0.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_rgb` and `pix_transparent` hold their values.
- R10: `done` is high for exactly one cycle: the cycle right after the clock edge that accepts the 64th pixel.
- R11: After reset, `start_ready`=1, and `pix_valid`, `done`, `vram_rd_en` and `cram_rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | A tile name is offered |
| start_ready | output | 1 | Fetcher is idle and will take a name |
| start_name | input | 15 | Tile name: index [10:0], horizontal mirror [11], vertical mirror [12], palette [14:13] |
| vram_rd_en | output | 1 | Video memory byte read strobe |
| vram_rd_addr | output | 16 | Video memory byte address |
| vram_rd_data | input | 8 | Byte read, valid the cycle after the strobe |
| cram_rd_en | output | 1 | Colour memory read strobe |
| cram_rd_addr | output | 6 | Colour word index {palette, colour} |
| cram_rd_data | input | 12 | Colour bits 11:0 of the word, valid the cycle after the strobe |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_rgb | output | 24 | Expanded colour, 8 bits per channel |
| pix_transparent | output | 1 | Pixel is see-through (colour 0) |
| done | output | 1 | One-cycle pulse after the final pixel of a tile |

## Verification
The properties assume that both memories answer exactly one cycle after each strobe. They also assume that reset is asserted before the first tile. Nothing is assumed about how the consumer drives ready or about when start_valid rises. The bench models both memories as registered reads, which keeps the latency contract by construction. It toggles the consumer's ready at random, so backpressure can land on any pixel. While a tile is in progress, it holds start_valid high with a different name, which exercises the rule that a busy fetcher ignores new starts.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_VREQ = 3'd1,
        ST_VCAP = 3'd2,
        ST_CREQ = 3'd3,
        ST_CCAP = 3'd4,
        ST_OUT  = 3'd5
    } fetch_state_e;

endpackage

// File: rtl/tpf_name_decode.sv
module tpf_name_decode #(
    parameter int IDX_W    = 11,
    parameter int PAL_BITS = 2,
    localparam int NAME_W  = IDX_W + 2 + PAL_BITS
) (
    input  logic [NAME_W-1:0]   name,
    output logic [IDX_W-1:0]    tile_idx,
    output logic                mirror_h,
    output logic                mirror_v,
    output logic [PAL_BITS-1:0] palette
);
    always_comb begin
        tile_idx = name[IDX_W-1:0];
        mirror_h = name[IDX_W];
        mirror_v = name[IDX_W+1];
        palette  = name[IDX_W+2 +: PAL_BITS];
    end
endmodule

// File: rtl/tpf_byte_addr.sv
module tpf_byte_addr #(
    parameter int IDX_W    = 11,
    parameter int TILE_DIM = 8,
    localparam int ROW_W   = $clog2(TILE_DIM),
    localparam int COL_W   = ROW_W - 1,
    localparam int CNT_W   = 2 * ROW_W,
    localparam int ADDR_W  = IDX_W + ROW_W + COL_W
) (
    input  logic [IDX_W-1:0]  tile_idx,
    input  logic              mirror_h,
    input  logic              mirror_v,
    input  logic [CNT_W-1:0]  pix_idx,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              take_high
);
    logic [ROW_W-1:0] row_scr, row_mem;
    logic [COL_W-1:0] col_scr, col_mem;

    always_comb begin
        row_scr   = pix_idx[CNT_W-1 -: ROW_W];
        col_scr   = pix_idx[ROW_W-1:1];
        row_mem   = mirror_v ? ~row_scr : row_scr;
        col_mem   = mirror_h ? ~col_scr : col_scr;
        byte_addr = {tile_idx, row_mem, col_mem};
        take_high = (pix_idx[0] == mirror_h);
    end
endmodule

// File: rtl/tpf_colour_expand.sv
module tpf_colour_expand #(
    parameter int FIELD_W = 4,
    parameter int CH_W    = 8,
    parameter int N_CH    = 3
) (
    input  logic [N_CH*FIELD_W-1:0] word,
    output logic [N_CH*CH_W-1:0]    rgb
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        assign rgb[(N_CH-1-ch)*CH_W +: CH_W] =
            {word[ch*FIELD_W +: FIELD_W], {(CH_W-FIELD_W){1'b0}}};
    end
endmodule

// File: rtl/tile_pixel_fetcher.sv
module tile_pixel_fetcher #(
    parameter int IDX_W    = 11,
    parameter int TILE_DIM = 8,
    parameter int PIX_W    = 4,
    parameter int PAL_BITS = 2,
    parameter int CH_W     = 8,
    localparam int NAME_W  = IDX_W + 2 + PAL_BITS,
    localparam int ROW_W   = $clog2(TILE_DIM),
    localparam int CNT_W   = 2 * ROW_W,
    localparam int TILE_PIX = TILE_DIM * TILE_DIM,
    localparam int VRAM_AW = IDX_W + 2 * ROW_W - 1,
    localparam int CRAM_AW = PAL_BITS + PIX_W,
    localparam int CRAM_DW = 3 * PIX_W,
    localparam int RGB_W   = 3 * CH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    output logic               start_ready,
    input  logic [NAME_W-1:0]  start_name,
    output logic               vram_rd_en,
    output logic [VRAM_AW-1:0] vram_rd_addr,
    input  logic [7:0]         vram_rd_data,
    output logic               cram_rd_en,
    output logic [CRAM_AW-1:0] cram_rd_addr,
    input  logic [CRAM_DW-1:0] cram_rd_data,
    output logic               pix_valid,
    input  logic               pix_ready,
    output logic [RGB_W-1:0]   pix_rgb,
    output logic               pix_transparent,
    output logic               done
);
    import tpf_pkg::*;

    localparam logic [CNT_W-1:0] LAST_PIX = CNT_W'(TILE_PIX - 1);

    typedef struct packed {
        fetch_state_e      state;
        logic [NAME_W-1:0] name;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        pbyte;
        logic [RGB_W-1:0]  rgb;
        logic              transp;
        logic              valid;
        logic              done;
    } fetch_regs_t;

    fetch_regs_t r_d, r_q;

    logic [IDX_W-1:0]    tile_idx;
    logic                mirror_h, mirror_v, take_high;
    logic [PAL_BITS-1:0] palette;
    logic [PIX_W-1:0]    colour;
    logic [RGB_W-1:0]    rgb_exp;

    tpf_name_decode #(.IDX_W(IDX_W), .PAL_BITS(PAL_BITS)) u_dec (
        .name     (r_q.name),
        .tile_idx (tile_idx),
        .mirror_h (mirror_h),
        .mirror_v (mirror_v),
        .palette  (palette)
    );

    tpf_byte_addr #(.IDX_W(IDX_W), .TILE_DIM(TILE_DIM)) u_addr (
        .tile_idx  (tile_idx),
        .mirror_h  (mirror_h),
        .mirror_v  (mirror_v),
        .pix_idx   (r_q.cnt),
        .byte_addr (vram_rd_addr),
        .take_high (take_high)
    );

    tpf_colour_expand #(.FIELD_W(PIX_W), .CH_W(CH_W), .N_CH(3)) u_exp (
        .word (cram_rd_data),
        .rgb  (rgb_exp)
    );

    assign colour = take_high ? r_q.pbyte[7:4] : r_q.pbyte[3:0];

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        vram_rd_en = 1'b0;
        cram_rd_en = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_valid) begin
                    r_d.name  = start_name;
                    r_d.cnt   = '0;
                    r_d.state = ST_VREQ;
                end
            end
            ST_VREQ: begin
                vram_rd_en = 1'b1;
                r_d.state  = ST_VCAP;
            end
            ST_VCAP: begin
                r_d.pbyte = vram_rd_data;
                r_d.state = ST_CREQ;
            end
            ST_CREQ: begin
                if (colour == '0) begin
                    r_d.rgb    = '0;
                    r_d.transp = 1'b1;
                    r_d.valid  = 1'b1;
                    r_d.state  = ST_OUT;
                end else begin
                    cram_rd_en = 1'b1;
                    r_d.state  = ST_CCAP;
                end
            end
            ST_CCAP: begin
                r_d.rgb    = rgb_exp;
                r_d.transp = 1'b0;
                r_d.valid  = 1'b1;
                r_d.state  = ST_OUT;
            end
            ST_OUT: begin
                if (pix_ready) begin
                    r_d.valid = 1'b0;
                    if (r_q.cnt == LAST_PIX) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.cnt   = r_q.cnt + 1'b1;
                        r_d.state = r_q.cnt[0] ? ST_VREQ : ST_CREQ;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign start_ready     = (r_q.state == ST_IDLE);
    assign cram_rd_addr    = {palette, colour};
    assign pix_valid       = r_q.valid;
    assign pix_rgb         = r_q.rgb;
    assign pix_transparent = r_q.transp;
    assign done            = r_q.done;

endmodule

// File: rtl/tpf_checker.sv
module tpf_checker #(
    parameter int CRAM_AW = 6,
    parameter int PIX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_valid,
    input logic               start_ready,
    input logic               cram_rd_en,
    input logic [CRAM_AW-1:0] cram_rd_addr,
    input logic               pix_valid,
    input logic               pix_ready,
    input logic [23:0]        pix_rgb,
    input logic               pix_transparent,
    input logic               done
);
    assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && start_ready |=> !start_ready);

    assert_no_cram_for_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cram_rd_en |-> cram_rd_addr[PIX_W-1:0] != '0);

    assert_transp_black_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_transparent |-> pix_rgb == 24'h0);

    assert_low_nibbles_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_rgb & 24'h0F0F0F) == 24'h0);

    assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_rgb) && $stable(pix_transparent));

    assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pix_valid && pix_ready));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind tile_pixel_fetcher tpf_checker #(.CRAM_AW(6), .PIX_W(4)) u_tpf_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_valid     (start_valid),
    .start_ready     (start_ready),
    .cram_rd_en      (cram_rd_en),
    .cram_rd_addr    (cram_rd_addr),
    .pix_valid       (pix_valid),
    .pix_ready       (pix_ready),
    .pix_rgb         (pix_rgb),
    .pix_transparent (pix_transparent),
    .done            (done)
);

// File: tb/tb_tile_pixel_fetcher.sv
`timescale 1ns/1ps
module tb_tile_pixel_fetcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [14:0] start_name = '0;
    logic        vram_rd_en;
    logic [15:0] vram_rd_addr;
    logic [7:0]  vram_rd_data = '0;
    logic        cram_rd_en;
    logic [5:0]  cram_rd_addr;
    logic [11:0] cram_rd_data = '0;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [23:0] pix_rgb;
    logic        pix_transparent;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [7:0]  vseed = 8'h00;
    logic [11:0] cram_mem [64];

    always #5 clk = ~clk;

    tile_pixel_fetcher dut (.*);

    function automatic logic [7:0] vbyte(input logic [15:0] a, input logic [7:0] s);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ s ^ {a[3:0], 4'h0};
    endfunction

    always @(posedge clk) begin
        if (vram_rd_en) vram_rd_data <= vbyte(vram_rd_addr, vseed);
        if (cram_rd_en) cram_rd_data <= cram_mem[cram_rd_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R6: no colour memory read for colour 0
    always @(negedge clk) begin
        if (rst_n && cram_rd_en && cram_rd_addr[3:0] == 4'h0)
            chk(1'b0, "R6 cram read for colour 0", {26'h0, cram_rd_addr}, 32'h1);
    end

    // expected pixel from R2..R8
    task automatic expect_pix(input logic [14:0] nm, input int k,
                              output logic [23:0] ergb, output logic etr);
        logic [2:0] r;
        logic [1:0] c;
        logic [7:0] b;
        logic [3:0] nib;
        logic [11:0] w;
        logic [5:0] kk;
        kk = 6'(k);
        r = nm[12] ? 3'(7 - kk[5:3]) : kk[5:3];
        c = nm[11] ? 2'(3 - kk[2:1]) : kk[2:1];
        b = vbyte({nm[10:0], r, c}, vseed);
        if (nm[11]) nib = kk[0] ? b[7:4] : b[3:0];
        else        nib = kk[0] ? b[3:0] : b[7:4];
        if (nib == 4'h0) begin
            ergb = 24'h0; etr = 1'b1;
        end else begin
            w = cram_mem[{nm[14:13], nib}];
            ergb = {w[3:0], 4'h0, w[7:4], 4'h0, w[11:8], 4'h0};
            etr = 1'b0;
        end
    endtask

    task automatic run_tile(input logic [14:0] nm);
        int k;
        bit held;
        logic [23:0] hr, er;
        logic ht, et;
        @(negedge clk);
        chk(start_ready == 1'b1, "R1 ready when idle", {31'h0, start_ready}, 32'h1);
        start_valid = 1'b1;
        start_name  = nm;
        @(negedge clk);
        start_name = ~nm;   // R1: must be ignored while busy
        chk(start_ready == 1'b0, "R1 busy after start", {31'h0, start_ready}, 32'h0);
        k = 0;
        held = 0;
        hr = '0; ht = 0;
        while (k < 64) begin
            pix_ready = ($urandom % 4) != 0;
            if (held)
                chk(pix_valid && pix_rgb == hr && pix_transparent == ht, "R9 hold under stall",
                    {7'h0, pix_valid, pix_rgb}, {7'h0, 1'b1, hr});
            held = 0;
            if (pix_valid) begin
                if (pix_ready) begin
                    expect_pix(nm, k, er, et);
                    chk(pix_rgb == er && pix_transparent == et, "R2/R3/R4/R5/R6/R7/R8 pixel",
                        {7'h0, pix_transparent, pix_rgb}, {7'h0, et, er});
                    if (k == 0 || k == 63)
                        chk(done == 1'b0, "R10 no early done", {31'h0, done}, 32'h0);
                    k++;
                end else begin
                    held = 1; hr = pix_rgb; ht = pix_transparent;
                end
            end
            @(negedge clk);
        end
        pix_ready   = 1'b0;
        start_valid = 1'b0;
        chk(done == 1'b1, "R10 done after last pixel", {31'h0, done}, 32'h1);
        chk(pix_valid == 1'b0, "R5 no 65th pixel", {31'h0, pix_valid}, 32'h0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", {31'h0, done}, 32'h0);
        chk(pix_valid == 1'b0, "R5 idle after tile", {31'h0, pix_valid}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 64; i++) cram_mem[i] = 12'($urandom);
        cram_mem[6'h3F] = 12'hFFF;
        cram_mem[6'h21] = 12'h123;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(start_ready == 1'b1, "R11 reset ready", {31'h0, start_ready}, 32'h1);
        chk(pix_valid == 1'b0 && done == 1'b0, "R11 reset outputs", {30'h0, pix_valid, done}, 32'h0);
        chk(vram_rd_en == 1'b0 && cram_rd_en == 1'b0, "R11 reset strobes",
            {30'h0, vram_rd_en, cram_rd_en}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(start_ready == 1'b1 && pix_valid == 1'b0, "R11 after release",
            {30'h0, start_ready, pix_valid}, 32'h2);
        // directed: plain, mirror H (R4), mirror V (R3), both + palette 3 + top index (R7)
        vseed = 8'h00; run_tile(15'h0000);
        vseed = 8'h11; run_tile(15'h0801);
        vseed = 8'h22; run_tile(15'h1002);
        vseed = 8'h33; run_tile(15'h7FFF);
        vseed = 8'h44; run_tile(15'h2403);
        for (int t = 0; t < 16; t++) begin
            vseed = 8'($urandom);
            run_tile(15'($urandom));
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule